// File: doc/BRIEF.md
# Receive Timestamp Header Inserter

This block sits in the receive path between the stage that packs converter samples into 64-bit words and the DMA engine that writes those words to memory. It counts the data words that pass through it. At the start of each block of a programmed length, it places one extra word in the stream ahead of the block's data. That word holds the value of a free-running 64-bit sample counter. If the DMA buffer size matches the block length, every buffer the DMA fills begins with the time at which its first sample arrived. Because the count is in sample-clock ticks and is 64 bits wide, it never wraps in practice.

The output carries a per-word marker that tells the DMA which words may open a buffer. Starting transfers only on marked words keeps buffers aligned to blocks. A block length of zero turns insertion off. In that mode words pass through unchanged and every word is marked as a legal start. Writing a new block length restarts the block count, so the next accepted word opens a new block.

Top module: `rx_ts_header_inserter`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: With a non-zero block length L, the first data word accepted after reset or after a length change is preceded on the output by one header word. After that, exactly one header precedes every L further accepted data words.
- R3: A header word carries the value `ts_in` had in the clock cycle in which the block's first data word was accepted.
- R4: Data words leave in the order they were accepted, unchanged, with none lost and none duplicated, under any valid/ready pattern on either side.
- R5: While a header word is on the output in enabled mode, `in_ready` is low. The block's first data word is held inside the block until the header has been taken.
- R6: In enabled mode, `out_sync` is 1 on header words and 0 on data words.
- R7: A block length of 0 selects pass-through. No header is inserted, every word appears unchanged, and `out_sync` is 1 on each word.
- R8: A new value on `blk_len` takes effect one clock cycle later and resets the block count to zero, so the next accepted word opens a new block.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sync` hold their values.
- R10: A word accepted on a clock edge is presented on the output from that same edge, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_in | input | 64 | Free-running sample-tick count |
| blk_len | input | 32 | Data words per block; 0 = pass-through |
| in_data | input | 64 | Packed sample word from upstream |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| out_data | output | 64 | Header or data word to DMA |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | DMA takes the output word |
| out_sync | output | 1 | Word is a legal buffer start |

## Verification
A word accepted on an edge is on the output in the cycle after that edge. The header for a block goes out first, and its data word follows in the cycle after the header is taken. The bench therefore drives inputs at the falling edge and settles for a short delay. It then predicts which handshakes the next rising edge will complete and stamps each accepted word with the `ts_in` value present at that edge into an arithmetic model queue. Output words are popped and compared only in cycles where `out_valid` and `out_ready` are both high. The stall, hold and one-cycle-latency checks compare values across consecutive falling edges. A length change is followed by three idle cycles, which covers its one-cycle delay.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned LEN_W  = 32;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HEAD = 1'b1
    } tsi_state_e;

    // a header is owed when a counted word opens a block
    function automatic logic opens_block(input logic accepted,
                                         input logic count_zero,
                                         input logic pass_mode);
        return accepted && count_zero && !pass_mode;
    endfunction

endpackage

// File: rtl/tsi_blk_counter.sv
module tsi_blk_counter #(
    parameter int unsigned LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len_in,
    input  logic             step,
    output logic [LEN_W-1:0] len_q,
    output logic             at_start
);

    logic [LEN_W-1:0] cnt;
    logic             len_new;

    assign len_new  = (len_in != len_q);
    assign at_start = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            len_q <= '0;
        end else begin
            len_q <= len_in;
            if (len_new) begin
                cnt <= '0;
            end else if (step) begin
                if (cnt == len_q - 1'b1) cnt <= '0;
                else                     cnt <= cnt + 1'b1;
            end
        end
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        (len_q != '0) |-> (cnt < len_q));

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        len_new |=> at_start);

endmodule

// File: rtl/tsi_out_stage.sv
module tsi_out_stage #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_sync,
    input  logic         take,
    output logic         ov,
    output logic [W-1:0] od,
    output logic         osync
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ov    <= 1'b0;
            od    <= '0;
            osync <= 1'b0;
        end else if (load) begin
            ov    <= 1'b1;
            od    <= load_data;
            osync <= load_sync;
        end else if (take) begin
            ov    <= 1'b0;
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ov && !take) |=> (ov && $stable(od) && $stable(osync)));

endmodule

// File: rtl/rx_ts_header_inserter.sv
module rx_ts_header_inserter
    import tsi_pkg::*;
#(
    parameter int unsigned DW = WORD_W,
    parameter int unsigned LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] ts_in,
    input  logic [LW-1:0] blk_len,
    input  logic [DW-1:0] in_data,
    input  logic          in_valid,
    output logic          in_ready,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_sync
);

    tsi_state_e    st;
    logic [DW-1:0] skid;
    logic [LW-1:0] len_q;
    logic          count_zero;
    logic          pass_mode;
    logic          fire;
    logic          room;
    logic          acc;
    logic          hdr_now;
    logic          load;
    logic [DW-1:0] load_data;
    logic          load_sync;

    assign pass_mode = (len_q == '0);
    assign fire      = out_valid && out_ready;
    assign room      = !out_valid || out_ready;
    assign in_ready  = (st == ST_RUN) && room;
    assign acc       = in_valid && in_ready;
    assign hdr_now   = opens_block(acc, count_zero, pass_mode);

    always_comb begin
        load      = acc;
        load_data = in_data;
        load_sync = pass_mode;
        if (st == ST_HEAD) begin
            load      = fire;
            load_data = skid;
            load_sync = 1'b0;
        end else if (hdr_now) begin
            load_data = ts_in;
            load_sync = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_RUN;
            skid <= '0;
        end else begin
            if (hdr_now) begin
                st   <= ST_HEAD;
                skid <= in_data;
            end else if (st == ST_HEAD && fire) begin
                st <= ST_RUN;
            end
        end
    end

    tsi_blk_counter #(.LEN_W(LW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .len_in   (blk_len),
        .step     (acc && !pass_mode),
        .len_q    (len_q),
        .at_start (count_zero)
    );

    tsi_out_stage #(.W(DW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .load_sync (load_sync),
        .take      (fire),
        .ov        (out_valid),
        .od        (out_data),
        .osync     (out_sync)
    );

    assert_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HEAD) |-> !in_ready);

    assert_hdr_time_R3: assert property (@(posedge clk) disable iff (rst)
        hdr_now |=> (out_valid && out_sync && out_data == $past(ts_in)));

    assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && pass_mode) |=> (out_sync && out_data == $past(in_data)));

    assert_first_data_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HEAD && fire) |=> (out_valid && !out_sync && out_data == $past(skid)));

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

endmodule

// File: tb/tb_rx_ts_header_inserter.sv
module tb_rx_ts_header_inserter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] ts_in = 64'd0;
    logic [31:0] blk_len = 32'd0;
    logic [63:0] in_data = 64'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_sync;

    int total = 0;
    int bad = 0;

    logic [64:0] expq[$];
    int          model_len = 0;
    int          k = 0;
    int          accepted = 0;
    logic [63:0] next_data = 64'hA500_0000_0000_0000;
    logic        drive_en = 1'b0;
    int          vmode = 0;
    int          rmode = 0;
    int          cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_stall = 1'b0;
    logic [63:0] prev_data = 64'd0;
    logic        prev_sync = 1'b0;
    logic        prev_acc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ts_header_inserter dut (
        .clk(clk), .rst(rst), .ts_in(ts_in), .blk_len(blk_len),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_sync(out_sync)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [64:0] got, input logic [64:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic pat(input int mode, input int sel);
        case (mode)
            0:       return 1'b1;
            1:       return lfsr[sel*5];
            default: return ((cyc + sel) % 3) != 0;
        endcase
    endfunction

    task automatic monitor();
        logic [64:0] e;
        if (prev_stall)
            check(out_valid && out_data == prev_data && out_sync == prev_sync,
                  "R9 hold", {out_sync, out_data}, {prev_sync, prev_data});
        if (prev_acc)
            check(out_valid, "R10 latency", {64'd0, out_valid}, 65'd1);
        if (out_valid && out_sync && model_len != 0)
            check(!in_ready, "R5 stall", {64'd0, in_ready}, 65'd0);
        if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
                check(1'b0, "R4 extra word", {out_sync, out_data}, 65'd0);
            end else begin
                e = expq.pop_front();
                if (model_len == 0)
                    check({out_sync, out_data} == e, "R7 pass", {out_sync, out_data}, e);
                else if (e[64])
                    check({out_sync, out_data} == e, "R2 R3 R6 header", {out_sync, out_data}, e);
                else
                    check({out_sync, out_data} == e, "R4 R6 data", {out_sync, out_data}, e);
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        prev_sync  = out_sync;
        prev_acc   = in_valid && in_ready;
        if (in_valid && in_ready) begin
            if (model_len != 0 && k == 0) expq.push_back({1'b1, ts_in});
            expq.push_back({(model_len == 0), in_data});
            if (model_len != 0) k = (k + 1 == model_len) ? 0 : k + 1;
            next_data = next_data + 64'h0001_0000_0000_0003;
            accepted++;
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        ts_in     = ts_in + 64'd1;
        in_valid  = drive_en && pat(vmode, 0);
        in_data   = next_data;
        out_ready = pat(rmode, 1);
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1;
        monitor();
    endtask

    task automatic drain();
        drive_en = 1'b0;
        rmode    = 0;
        for (int i = 0; i < 60 && (expq.size() != 0 || out_valid); i++) step();
        check(expq.size() == 0 && !out_valid, "R4 drained",
              {64'd0, out_valid}, 65'd0);
    endtask

    task automatic phase(input int len, input int vm, input int rm, input int n);
        blk_len   = len;
        model_len = len;
        k         = 0;          // R8: new length restarts the block
        drive_en  = 1'b0;
        for (int i = 0; i < 3; i++) step();
        vmode    = vm;
        rmode    = rm;
        accepted = 0;
        drive_en = 1'b1;
        for (int i = 0; i < 5000 && accepted < n; i++) step();
        drain();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        blk_len = 32'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!out_valid && in_ready, "R1 reset",
              {63'd0, out_valid, in_ready}, 65'd1);
        phase(1, 0, 0, 6);
        phase(2, 1, 1, 20);
        phase(3, 2, 1, 30);
        phase(5, 1, 2, 7);      // ends mid-block
        phase(4, 1, 1, 25);     // R8 rewrite restarts count
        phase(0, 1, 1, 20);     // R7 pass-through
        phase(3, 0, 1, 12);
        phase(0, 0, 0, 5);
        phase(7, 1, 1, 40);
        phase(2, 2, 2, 18);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule